// File: doc/BRIEF.md
# Ratio-Coded Single-Wire Command Transmitter

This block is the controller side of a one-wire brightness command link. It takes a 9-bit brightness code and an acknowledge-request flag through a valid/ready handshake. From them it forms a 24-bit command word. The upper byte of that word is a fixed slave address. The word is sent over an open-drain line. The block never drives the line high: it either pulls the line low or releases it, and an external pull-up holds the line high when released.

A frame has three parts. The first is a released start interval. The second is 24 bits, sent lowest bit first. Each bit begins with a falling edge and is encoded by the ratio of its low time to its high time. The third part depends on the acknowledge flag. Without an acknowledge request, the frame ends with a low end-of-stream interval. With a request, the block holds the line low for a validation delay. It then releases the line and samples it once, through a synchroniser, inside a listen window. A one-cycle `ack_ok` pulse means the slave held the line low at that point. A one-cycle `ack_fail` pulse means the line was high.

All timing is set by cycle-count parameters. `UNIT_CYC` is one time unit, and a bit is four units long. The other parameters are `START_CYC`, `EOS_CYC`, `VAL_CYC`, `ACK_WIN_CYC` and `ACK_SMP_CYC`. They are chosen so that each interval meets the link's minimum times of 2 µs for start and end-of-stream and up to 512 µs for the acknowledge window. `ACK_SMP_CYC` must be at least `SYNC_STAGES` and smaller than `ACK_WIN_CYC - 1`.

Back-pressure works as follows. `cmd_ready` is high only while the block is idle. A command is taken in the cycle where both `cmd_valid` and `cmd_ready` are high. A command offered while the block is busy stays pending and is not lost. The fields are captured at the handshake, so later changes on the inputs do not affect the frame in progress.

Top module: `ratio_line_tx`

## Requirements
- R1: During and straight after reset, the line is released, `busy` is low, `cmd_ready` is high, and neither `ack_ok` nor `ack_fail` is asserted.
- R2: The frame carries, in this order, bit 0 through bit 23 of a word built as follows. Bits 23..16 are 8'h8F. Bits 8..0 are the brightness code. Bit 10 is the acknowledge flag. Bits 15..11 and bit 9 are 0.
- R3: In the cycle after a handshake, `busy` rises and the line stays released for `START_CYC` cycles. The first bit then starts by pulling the line low.
- R4: A 0 bit is pulled low for 3·`UNIT_CYC` cycles and then released for `UNIT_CYC` cycles. A 1 bit is pulled low for `UNIT_CYC` cycles and then released for 3·`UNIT_CYC` cycles.
- R5: Without an acknowledge request, the high phase of bit 23 is followed by `EOS_CYC` low cycles. After that the line is released and `busy` falls in the same cycle.
- R6: With an acknowledge request, the high phase of bit 23 is followed by `VAL_CYC` low cycles. The line is then released for `ACK_WIN_CYC` cycles, and `busy` stays high until that window ends.
- R7: The synchronised line is sampled in listen cycle `ACK_SMP_CYC`, counting from 0. In the next cycle exactly one of `ack_ok` (line low) or `ack_fail` (line high) is asserted, for one cycle only.
- R8: `cmd_ready` is high only when `busy` is low. A command held valid while the block is busy is taken in the first idle cycle. Changing the inputs after the handshake does not change the frame being sent.
- R9: A frame sent without an acknowledge request produces no `ack_ok` or `ack_fail` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block accepts a command (idle) |
| cmd_level | input | 9 | Brightness code |
| cmd_ack_req | input | 1 | Request the acknowledge handshake |
| line_in | input | 1 | Level read back from the wire |
| line_drive_low | output | 1 | 1 pulls the wire low, 0 releases it |
| busy | output | 1 | A frame or acknowledge window is in progress |
| ack_ok | output | 1 | One-cycle pulse: the slave acknowledged |
| ack_fail | output | 1 | One-cycle pulse: no acknowledge was seen |

## Verification
The frame is exercised with four brightness codes, each chosen to catch a different class of fault:
- An all-zero code and an all-ones code show a swapped low/high ratio.
- Two alternating codes show a bit-order or shift fault.
- A behavioural model compares the line, `busy`, `cmd_ready` and the result pulses in every cycle. A separate ratio decoder on the wire recovers each 24-bit word and compares it with the word built from the requirements.

The acknowledge path is tried twice: once with a slave that pulls the line low, to expect `ack_ok`, and once without, to expect `ack_fail`. In a back-to-back run, `cmd_valid` stays high and the code changes while the block is busy, which checks capture at the handshake and acceptance in the first idle cycle.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

  localparam int          RWT_WORD_BITS = 24;
  localparam int          RWT_CODE_BITS = 9;
  localparam logic [7:0]  RWT_ADDR      = 8'h8F;
  localparam int          RWT_ACK_POS   = 10;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_HIGH,
    PH_EOS,
    PH_HOLD,
    PH_LISTEN
  } rwt_phase_e;

  function automatic int rwt_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Assemble the command word; unused data bits stay zero.
  function automatic logic [RWT_WORD_BITS-1:0] rwt_word(
    input logic [RWT_CODE_BITS-1:0] code,
    input logic                     ack
  );
    logic [RWT_WORD_BITS-1:0] w;
    w = '0;
    w[RWT_CODE_BITS-1:0] = code;
    w[RWT_ACK_POS]       = ack;
    w[23:16]             = RWT_ADDR;
    return w;
  endfunction

endpackage

// File: rtl/rwt_timer.sv
module rwt_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

endmodule

// File: rtl/rwt_shifter.sv
module rwt_shifter #(
  parameter int BITS = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_word,
  input  logic            shift,
  output logic            cur_bit,
  output logic            nxt_bit,
  output logic            last_bit
);

  localparam int IW = $clog2(BITS);

  logic [BITS-1:0] word_q;
  logic [IW-1:0]   idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= load_word;
      idx_q  <= '0;
    end else if (shift) begin
      word_q <= {1'b0, word_q[BITS-1:1]};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = word_q[0];
  assign nxt_bit  = word_q[1];
  assign last_bit = (idx_q == IW'(BITS-1));

endmodule

// File: rtl/rwt_sync.sv
module rwt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] s_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= {s_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = s_q[STAGES-1];

endmodule

// File: rtl/ratio_line_tx.sv
module ratio_line_tx
  import rwt_pkg::*;
#(
  parameter int UNIT_CYC    = 4,
  parameter int START_CYC   = 8,
  parameter int EOS_CYC     = 8,
  parameter int VAL_CYC     = 12,
  parameter int ACK_WIN_CYC = 16,
  parameter int ACK_SMP_CYC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [RWT_CODE_BITS-1:0] cmd_level,
  input  logic                     cmd_ack_req,
  input  logic                     line_in,
  output logic                     line_drive_low,
  output logic                     busy,
  output logic                     ack_ok,
  output logic                     ack_fail
);

  localparam int LONG_CYC    = 3 * UNIT_CYC;
  localparam int LOW_RUN_MAX = rwt_max(LONG_CYC, rwt_max(EOS_CYC, VAL_CYC));
  localparam int LEN_MAX     = rwt_max(LOW_RUN_MAX, rwt_max(START_CYC, ACK_WIN_CYC));
  localparam int TW          = $clog2(LEN_MAX + 1);
  localparam logic [TW-1:0] SMP_CNT = TW'(ACK_WIN_CYC - 1 - ACK_SMP_CYC);

  rwt_phase_e    phase_q, phase_d;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val, t_count;
  logic          s_load, s_shift, cur_bit, nxt_bit, last_bit;
  logic          ack_want_q;
  logic          line_s;
  logic          sample_pt;

  function automatic logic [TW-1:0] low_len(input logic b);
    return b ? TW'(UNIT_CYC - 1) : TW'(LONG_CYC - 1);
  endfunction

  function automatic logic [TW-1:0] high_len(input logic b);
    return b ? TW'(LONG_CYC - 1) : TW'(UNIT_CYC - 1);
  endfunction

  rwt_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .count    (t_count),
    .zero     (t_zero)
  );

  rwt_shifter #(.BITS(RWT_WORD_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (s_load),
    .load_word (rwt_word(cmd_level, cmd_ack_req)),
    .shift     (s_shift),
    .cur_bit   (cur_bit),
    .nxt_bit   (nxt_bit),
    .last_bit  (last_bit)
  );

  rwt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_in),
    .q     (line_s)
  );

  // Phase sequencing: each phase loads the timer with its length minus one.
  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    s_load  = 1'b0;
    s_shift = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (cmd_valid) begin
        phase_d = PH_START;
        t_load  = 1'b1;
        t_val   = TW'(START_CYC - 1);
        s_load  = 1'b1;
      end
      PH_START: if (t_zero) begin
        phase_d = PH_LOW;
        t_load  = 1'b1;
        t_val   = low_len(cur_bit);
      end
      PH_LOW: if (t_zero) begin
        phase_d = PH_HIGH;
        t_load  = 1'b1;
        t_val   = high_len(cur_bit);
      end
      PH_HIGH: if (t_zero) begin
        t_load  = 1'b1;
        s_shift = 1'b1;
        if (!last_bit) begin
          phase_d = PH_LOW;
          t_val   = low_len(nxt_bit);
        end else if (ack_want_q) begin
          phase_d = PH_HOLD;
          t_val   = TW'(VAL_CYC - 1);
        end else begin
          phase_d = PH_EOS;
          t_val   = TW'(EOS_CYC - 1);
        end
      end
      PH_EOS: if (t_zero) phase_d = PH_IDLE;
      PH_HOLD: if (t_zero) begin
        phase_d = PH_LISTEN;
        t_load  = 1'b1;
        t_val   = TW'(ACK_WIN_CYC - 1);
      end
      PH_LISTEN: if (t_zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      ack_want_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (s_load) ack_want_q <= cmd_ack_req;
    end
  end

  assign sample_pt = (phase_q == PH_LISTEN) && (t_count == SMP_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_ok   <= 1'b0;
      ack_fail <= 1'b0;
    end else begin
      ack_ok   <= sample_pt && !line_s;
      ack_fail <= sample_pt &&  line_s;
    end
  end

  assign line_drive_low = (phase_q == PH_LOW) || (phase_q == PH_EOS) ||
                          (phase_q == PH_HOLD);
  assign busy           = (phase_q != PH_IDLE);
  assign cmd_ready      = (phase_q == PH_IDLE);

endmodule

// File: rtl/rwt_chk.sv
module rwt_chk #(
  parameter int LOW_MAX = 12
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic line_drive_low,
  input logic ack_ok,
  input logic ack_fail
);

  localparam int CW = $clog2(LOW_MAX + 2);

  logic [CW-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run_q <= '0;
    else if (!line_drive_low) low_run_q <= '0;
    else if (low_run_q != CW'(LOW_MAX + 1)) low_run_q <= low_run_q + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!line_drive_low && !ack_ok && !ack_fail));

  // R3
  start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line_drive_low);

  // R4
  low_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= CW'(LOW_MAX));

  // R5
  end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !line_drive_low);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R7
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_ok, ack_fail}));

  // R7
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok || ack_fail) |=> !(ack_ok || ack_fail));

  // R7
  result_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok || ack_fail) |-> (busy && !line_drive_low));

endmodule

bind ratio_line_tx rwt_chk #(.LOW_MAX(LOW_RUN_MAX)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .busy           (busy),
  .line_drive_low (line_drive_low),
  .ack_ok         (ack_ok),
  .ack_fail       (ack_fail)
);

// File: tb/sim_ratio_line_tx.sv
`timescale 1ns/1ps
module sim_ratio_line_tx;

  localparam int U   = 4;
  localparam int STC = 8;
  localparam int EOC = 8;
  localparam int VLC = 12;
  localparam int AWC = 16;
  localparam int ASC = 4;

  typedef struct packed {
    logic drv;
    logic bsy;
    logic ok;
    logic fl;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd_level = '0;
  logic       cmd_ack_req = 1'b0;
  logic       slave_ack = 1'b0;
  logic       cmd_ready, line_drive_low, busy, ack_ok, ack_fail;
  wire        line_in = ~(line_drive_low | slave_ack);

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ratio_line_tx #(
    .UNIT_CYC(U), .START_CYC(STC), .EOS_CYC(EOC), .VAL_CYC(VLC),
    .ACK_WIN_CYC(AWC), .ACK_SMP_CYC(ASC), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_level(cmd_level), .cmd_ack_req(cmd_ack_req), .line_in(line_in),
    .line_drive_low(line_drive_low), .busy(busy), .ack_ok(ack_ok),
    .ack_fail(ack_fail)
  );

  // ---------------- behavioural reference ----------------
  exp_t        q[$];
  string       tq[$];
  string       rq[$];
  exp_t        cur = '0;
  string       cur_t = "R1";
  string       cur_r = "R1";
  logic [23:0] frame_word = '0;

  function automatic void put(input int n, input logic d, input logic b,
                              input logic o, input logic f,
                              input string t, input string r);
    for (int i = 0; i < n; i++) begin
      q.push_back('{drv: d, bsy: b, ok: o, fl: f});
      tq.push_back(t);
      rq.push_back(r);
    end
  endfunction

  function automatic void build(input logic [8:0] lvl, input logic ak,
                                input logic sl);
    logic [23:0] w;
    string rt;
    w = {8'h8F, 5'b00000, ak, 1'b0, lvl};
    frame_word = w;
    rt = ak ? "R7" : "R9";
    put(STC, 1'b0, 1'b1, 1'b0, 1'b0, "R3", rt);
    for (int i = 0; i < 24; i++) begin
      put(w[i] ? U : 3*U, 1'b1, 1'b1, 1'b0, 1'b0, "R4", rt);
      put(w[i] ? 3*U : U, 1'b0, 1'b1, 1'b0, 1'b0, "R4", rt);
    end
    if (!ak) begin
      put(EOC, 1'b1, 1'b1, 1'b0, 1'b0, "R5", rt);
    end else begin
      put(VLC, 1'b1, 1'b1, 1'b0, 1'b0, "R6", rt);
      for (int j = 0; j < AWC; j++)
        put(1, 1'b0, 1'b1, (j == ASC+1) && sl, (j == ASC+1) && !sl, "R6", rt);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); tq.delete(); rq.delete();
      cur = '0; cur_t = "R1"; cur_r = "R1";
    end else begin
      if (cmd_valid && !cur.bsy) build(cmd_level, cmd_ack_req, slave_ack);
      if (q.size() > 0) begin
        cur = q.pop_front(); cur_t = tq.pop_front(); cur_r = rq.pop_front();
      end else begin
        cur = '0; cur_t = "R8"; cur_r = "R9";
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (line_drive_low !== cur.drv || busy !== cur.bsy) begin
        fails++;
        $display("FAIL %s: drive/busy = %b%b, expected %b%b at %0t",
                 cur_t, line_drive_low, busy, cur.drv, cur.bsy, $time);
      end else if (cmd_ready !== !cur.bsy) begin
        fails++;
        $display("FAIL R8: cmd_ready = %b, expected %b at %0t",
                 cmd_ready, !cur.bsy, $time);
      end else if (ack_ok !== cur.ok || ack_fail !== cur.fl) begin
        fails++;
        $display("FAIL %s: ok/fail = %b%b, expected %b%b at %0t",
                 cur_r, ack_ok, ack_fail, cur.ok, cur.fl, $time);
      end
    end
  end

  // ---------------- ratio decoder on the wire (R2) ----------------
  int          lowc = 0, highc = 0, nb = 0;
  logic [23:0] got = '0;
  logic        prev_drv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy) begin
        lowc = 0; highc = 0; nb = 0;
      end else begin
        if (line_drive_low && !prev_drv) begin
          if (lowc > 0 && nb < 24) begin
            got[nb] = (highc > lowc);
            nb++;
            if (nb == 24) begin
              checks++;
              if (got !== frame_word) begin
                fails++;
                $display("FAIL R2: decoded word %h, expected %h", got, frame_word);
              end
            end
          end
          lowc = 0; highc = 0;
        end
        if (line_drive_low) lowc++; else highc++;
      end
    end
    prev_drv = line_drive_low;
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [8:0] lvl, input logic ak, input logic sl);
    logic r;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_level = lvl; cmd_ack_req = ak; slave_ack = sl;
    forever begin
      r = cmd_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_level = ~lvl;          // R8: changes after the handshake are ignored
    cmd_ack_req = ~ak;
    while (busy) @(negedge clk);
    slave_ack = 1'b0;
  endtask

  task automatic chk_r1(input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL R1: %s = %b, expected %b", what, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_r1(line_drive_low, 1'b0, "drive in reset");
    chk_r1(busy, 1'b0, "busy in reset");
    chk_r1(cmd_ready, 1'b1, "ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_r1(line_drive_low, 1'b0, "drive after reset");
    chk_r1(busy, 1'b0, "busy after reset");
    chk_r1(ack_ok | ack_fail, 1'b0, "result after reset");
    repeat (4) @(negedge clk);

    send(9'h000, 1'b0, 1'b0);   // R4 all zero bits, R5, R9
    send(9'h1FF, 1'b0, 1'b0);   // R4 all one bits
    send(9'h0A5, 1'b1, 1'b1);   // R6, R7 acknowledged
    send(9'h15A, 1'b1, 1'b0);   // R6, R7 not acknowledged

    // R8: back-to-back with valid held high and inputs changed while busy
    @(negedge clk);
    cmd_valid = 1'b1; cmd_level = 9'h123; cmd_ack_req = 1'b0;
    @(negedge clk);
    cmd_level = 9'h0F0; cmd_ack_req = 1'b1; slave_ack = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    slave_ack = 1'b0;
    repeat (10) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule